// File: doc/BRIEF.md
# Command Prefetch Step Generator

This block sequences the optional prefetch work that a storage host adapter port performs after a command frame has gone out to the device without error. A one-cycle strobe marks that successful transmission. On that strobe the block samples three per-command flags: prefetch enable, write direction and packet (ATAPI) command. From them it decides which prefetch steps to run.

There are three possible steps: fetch the packet command bytes, fetch the descriptor table, and fetch the outbound data. They always run in that order. Only the subset that applies to the command is run. The packet-command step runs only for packet commands, the data step runs only for writes, and the descriptor step runs whenever prefetch is enabled.

Each step is a request line that stays high until the unit doing the work answers with a done pulse. After the last step, or straight away when prefetch is disabled, the block emits a single-cycle return-to-idle strobe. A new success strobe that arrives while a sequence is still running is discarded and reported as an overlap error.

Top module: `pfs_top`

## Requirements
- R1: After a synchronous active-low reset, all three request outputs, the idle-return strobe and the overlap error are low.
- R2: When the prefetch flag is low at an accepted success strobe, the idle-return strobe is high for exactly one cycle, in the cycle after the strobe, and no request is raised.
- R3: With prefetch enabled on a non-packet read, only the descriptor request runs, followed by idle-return.
- R4: With prefetch enabled on a non-packet write, the descriptor request runs, then the data request, then idle-return.
- R5: With prefetch enabled on a packet read, the packet-command request runs, then the descriptor request, then idle-return.
- R6: With prefetch enabled on a packet write, the packet-command, descriptor and data requests run in that order, then idle-return.
- R7: The first request rises in the cycle after the accepted strobe. A request stays high until done is sampled high. The next request, or idle-return, rises in the cycle after that done, and idle-return lasts one cycle.
- R8: At most one request output is high in any cycle, and none is high while idle-return is high.
- R9: The flags are sampled only at the accepted strobe; changing them during a sequence does not change the steps that run.
- R10: A success strobe seen while a sequence is active, including its idle-return cycle, starts nothing and raises the overlap error for one cycle in the next cycle.
- R11: A done pulse while no request is active has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_sent_i | input | 1 | Command frame transmitted successfully (one-cycle strobe) |
| pf_en_i | input | 1 | Prefetch flag of the issued command |
| wr_i | input | 1 | Command moves data toward the device |
| pkt_i | input | 1 | Command is a packet (ATAPI) command |
| step_done_i | input | 1 | Current prefetch step has completed |
| req_pkt_o | output | 1 | Request: fetch packet command bytes |
| req_desc_o | output | 1 | Request: fetch descriptor table |
| req_data_o | output | 1 | Request: fetch outbound data |
| idle_ret_o | output | 1 | Sequence finished; port may return to idle |
| overlap_err_o | output | 1 | Strobe arrived during an active sequence |

## Verification
The sequencer keeps two pieces of state: the request in progress and the mask of steps still to run. Any corruption of either shows at the request pins one cycle after the next done pulse. It appears as a missing, repeated or reordered step, or as idle-return arriving early or late. A wrong busy decision shows within one cycle of a strobe, either as a spurious restart or as a missing overlap error. The bench sweeps every flag combination against several done latencies and checks the pins in every cycle. It also repeats the sweep with the flags inverted right after capture, and with done and strobe pulses applied at the wrong moments.

// File: rtl/pfs_pkg.sv
// Package: shared step encoding for the prefetch step generator.
// Bit index of a step equals its position in the fixed run order.
package pfs_pkg;
    localparam int STEP_N   = 3;
    localparam int IDX_PKT  = 0;
    localparam int IDX_DESC = 1;
    localparam int IDX_DATA = 2;

    typedef logic [STEP_N-1:0] step_mask_t;

    // Isolate the lowest set bit (earliest pending step in run order).
    function automatic step_mask_t lowest_one(step_mask_t m);
        return m & (~m + step_mask_t'(1));
    endfunction
endpackage

// File: rtl/pfs_plan.sv
// pfs_plan: turns the command flags into the mask of prefetch steps.
// Assumes: purely combinational; caller samples the result only at start.
module pfs_plan
    import pfs_pkg::*;
(
    input  logic       pf_en_i,
    input  logic       wr_i,
    input  logic       pkt_i,
    output step_mask_t mask_o
);
    // Select steps: packet bytes for packet commands, data for writes.
    always_comb begin
        mask_o = '0;
        if (pf_en_i) begin
            mask_o[IDX_PKT]  = pkt_i;
            mask_o[IDX_DESC] = 1'b1;
            mask_o[IDX_DATA] = wr_i;
        end
    end
endmodule

// File: rtl/pfs_seq.sv
// pfs_seq: walks a step mask from lowest to highest bit, one request at a
// time, each held until done, then pulses return-to-idle for one cycle.
// Assumes: start_i is asserted only while active_o is low.
module pfs_seq
    import pfs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  step_mask_t mask_i,
    input  logic       done_i,
    output step_mask_t req_o,
    output logic       ret_o,
    output logic       active_o
);
    step_mask_t req_q;
    step_mask_t rem_q;
    logic       ret_q;
    step_mask_t first_s;
    step_mask_t next_s;

    // Pick the earliest step of the new plan and of the remaining plan.
    always_comb begin
        first_s = lowest_one(mask_i);
        next_s  = lowest_one(rem_q);
    end

    // Advance the current request, remaining mask and return strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
            rem_q <= '0;
            ret_q <= 1'b0;
        end else if (start_i) begin
            req_q <= first_s;
            rem_q <= mask_i & ~first_s;
            ret_q <= (mask_i == '0);
        end else if ((req_q != '0) && done_i) begin
            req_q <= next_s;
            rem_q <= rem_q & ~next_s;
            ret_q <= (rem_q == '0);
        end else begin
            ret_q <= 1'b0;
        end
    end

    assign req_o    = req_q;
    assign ret_o    = ret_q;
    assign active_o = (req_q != '0) || ret_q;

    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_q) && !(ret_q && (req_q != '0))); // R8
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_q != '0) && !done_i && !start_i) |=> (req_q == $past(req_q))); // R7
    AST_RET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ret_q |=> !ret_q); // R7
endmodule

// File: rtl/pfs_top.sv
// pfs_top: prefetch step generator. Accepts a success strobe when idle,
// plans the steps from the flags sampled then, and runs them in order.
// A strobe during an active sequence is dropped and flagged for one cycle.
// Assumes: step_done_i is meaningful only while a request is high.
module pfs_top
    import pfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_sent_i,
    input  logic pf_en_i,
    input  logic wr_i,
    input  logic pkt_i,
    input  logic step_done_i,
    output logic req_pkt_o,
    output logic req_desc_o,
    output logic req_data_o,
    output logic idle_ret_o,
    output logic overlap_err_o
);
    step_mask_t plan_s;
    step_mask_t req_s;
    logic       busy_s;
    logic       accept_s;
    logic       ovl_q;

    pfs_plan u_plan (
        .pf_en_i (pf_en_i),
        .wr_i    (wr_i),
        .pkt_i   (pkt_i),
        .mask_o  (plan_s)
    );

    // Accept a strobe only when no sequence is in flight.
    assign accept_s = cmd_sent_i && !busy_s;

    pfs_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (accept_s),
        .mask_i   (plan_s),
        .done_i   (step_done_i),
        .req_o    (req_s),
        .ret_o    (idle_ret_o),
        .active_o (busy_s)
    );

    // Register a one-cycle overlap error for a strobe that was dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) ovl_q <= 1'b0;
        else        ovl_q <= cmd_sent_i && busy_s;
    end

    assign overlap_err_o = ovl_q;
    assign req_pkt_o     = req_s[IDX_PKT];
    assign req_desc_o    = req_s[IDX_DESC];
    assign req_data_o    = req_s[IDX_DATA];

    AST_OVERLAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_sent_i && busy_s) |=> (overlap_err_o && !$rose(req_pkt_o || req_desc_o))); // R10
    AST_NO_PF_RET: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_s && !pf_en_i) |=> (idle_ret_o && !req_pkt_o && !req_desc_o && !req_data_o)); // R2
    AST_PF_FIRST_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_s && pf_en_i) |=> (!idle_ret_o && (req_pkt_o || req_desc_o))); // R7
    AST_IDLE_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_s && !cmd_sent_i) |=> (!idle_ret_o && !req_pkt_o && !req_desc_o && !req_data_o)); // R11
endmodule

// File: tb/tb_pfs_top.sv
`timescale 1ns/1ps
// tb_pfs_top: sweeps flag combinations and done latencies, plus directed
// cases for overlap, stray done and flag changes mid-sequence.
module tb_pfs_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_sent_i = 1'b0, pf_en_i = 1'b0, wr_i = 1'b0, pkt_i = 1'b0, step_done_i = 1'b0;
    logic req_pkt_o, req_desc_o, req_data_o, idle_ret_o, overlap_err_o;

    int vecs = 0;
    int errs = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pfs_top dut (
        .clk(clk), .rst_n(rst_n), .cmd_sent_i(cmd_sent_i), .pf_en_i(pf_en_i),
        .wr_i(wr_i), .pkt_i(pkt_i), .step_done_i(step_done_i),
        .req_pkt_o(req_pkt_o), .req_desc_o(req_desc_o), .req_data_o(req_data_o),
        .idle_ret_o(idle_ret_o), .overlap_err_o(overlap_err_o)
    );

    // Output vector: {overlap, idle_ret, data, desc, pkt}.
    function automatic logic [4:0] outv();
        return {overlap_err_o, idle_ret_o, req_data_o, req_desc_o, req_pkt_o};
    endfunction

    task automatic check(string req, logic [4:0] exp);
        vecs++;
        if (outv() !== exp) begin
            errs++;
            $display("FAIL %s: got %b expected %b at %0t", req, outv(), exp, $time);
        end
    endtask

    // Run one command; check every cycle. scramble inverts flags after capture (R9).
    task automatic run(bit pf, bit wr, bit pkt, int lat, bit scramble);
        logic [2:0] plan;
        string tag;
        plan = pf ? {wr, 1'b1, pkt} : 3'b000;
        tag = !pf ? "R2" : (pkt ? (wr ? "R6" : "R5") : (wr ? "R4" : "R3"));
        @(negedge clk);
        cmd_sent_i = 1'b1; pf_en_i = pf; wr_i = wr; pkt_i = pkt;
        @(negedge clk);
        cmd_sent_i = 1'b0;
        if (scramble) begin pf_en_i = ~pf; wr_i = ~wr; pkt_i = ~pkt; end
        for (int i = 0; i < 3; i++) begin
            if (plan[i]) begin
                for (int w = 0; w < lat; w++) begin
                    check(scramble ? "R9" : "R7", {2'b00, 3'(1 << i)});
                    @(negedge clk);
                end
                check(tag, {2'b00, 3'(1 << i)});
                step_done_i = 1'b1;
                @(negedge clk);
                step_done_i = 1'b0;
            end
        end
        check(tag, 5'b01000);
        @(negedge clk);
        check("R7", 5'b00000);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", 5'b00000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 5'b00000);

        // Stray done while idle (R11).
        step_done_i = 1'b1;
        repeat (3) begin @(negedge clk); check("R11", 5'b00000); end
        step_done_i = 1'b0;

        // Full sweep of flags and done latency.
        for (int f = 0; f < 8; f++)
            for (int lat = 0; lat < 4; lat++)
                run(f[2], f[1], f[0], lat, 1'b0);
        for (int f = 0; f < 8; f++)
            run(f[2], f[1], f[0], 1, 1'b1);

        // Overlap during a request (R10): packet write, strobe while pkt active.
        @(negedge clk);
        cmd_sent_i = 1'b1; pf_en_i = 1'b1; wr_i = 1'b1; pkt_i = 1'b1;
        @(negedge clk);
        check("R10", 5'b00001);
        pf_en_i = 1'b0;
        @(negedge clk);
        cmd_sent_i = 1'b0;
        check("R10", 5'b10001);
        step_done_i = 1'b1; @(negedge clk); step_done_i = 1'b0;
        check("R10", 5'b00010);
        step_done_i = 1'b1; @(negedge clk); step_done_i = 1'b0;
        check("R10", 5'b00100);
        step_done_i = 1'b1; @(negedge clk); step_done_i = 1'b0;
        check("R10", 5'b01000);
        // Strobe during the idle-return cycle is also dropped.
        cmd_sent_i = 1'b1; pf_en_i = 1'b1;
        @(negedge clk);
        cmd_sent_i = 1'b0;
        check("R10", 5'b10000);
        @(negedge clk);
        check("R10", 5'b00000);

        // Prefetch off: strobe then strobe again right after idle (R2, R10).
        cmd_sent_i = 1'b1; pf_en_i = 1'b0;
        @(negedge clk);
        check("R2", 5'b01000);
        @(negedge clk);
        cmd_sent_i = 1'b0;
        check("R10", 5'b10000);
        @(negedge clk);
        check("R2", 5'b00000);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errs++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end
endmodule